// File: doc/BRIEF.md
# Stream Backpressure Timeout Timer

This block watches the read side of a memory-to-stream channel and reports when the downstream stream sink refuses data for too long. While transfer bytes remain and the sink holds its ready input low, a one-shot timer runs. It counts ticks of a programmable prescaler, and after a programmed number of ticks it emits a single-cycle pulse. An interrupt register file outside this block uses that pulse to set its stream-timeout flag.

The enable, prescaler value and timeout count come from control fields that are held elsewhere. In the surrounding register file the prescaler field resets to 0xFFF and the timeout count to 0xFFE. The timer latches both values at the moment it arms, so later writes affect only the next arm. If the sink becomes ready or the remaining byte count drops to zero, the run is abandoned. After an expiry, the timer stays quiet until the stall ends.

Top module: `stream_bp_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `tmo_pulse_o` is 0.
- R2: The timer arms only on a clock edge where `tmo_en_i`=1, `bytes_left_i`=1 and `sink_ready_i`=0 are all seen together. With `tmo_en_i`=0 a stall never produces a pulse. If the enable rises during a stall, the timer arms on that edge.
- R3: Let P be the prescaler value and T the timeout count, both captured at the arming edge E. One tick occurs every P+1 cycles. `tmo_pulse_o` is 1 for the cycle that follows edge E + T·(P+1).
- R4: A timeout count of 0 acts as 1, so the pulse follows edge E + (P+1).
- R5: The pulse lasts one cycle. While the stall continues after an expiry, no further pulse occurs.
- R6: The run is cancelled and no pulse is produced if `sink_ready_i`=1 or `bytes_left_i`=0 is seen on any edge up to and including the expiry edge.
- R7: After a cancel, a new arm restarts both the prescaler and the tick count from zero.
- R8: Changes to `presc_i` or `tmo_val_i` while the timer runs do not move the pending expiry.
- R9: If `tmo_en_i` is 0 on the expiry edge, the run ends without a pulse.
- R10: With `bytes_left_i`=0 the timer does not arm, even while the sink is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_en_i | input | 1 | Timeout enable |
| presc_i | input | PRE_W | Prescaler value; divides the clock by value+1 |
| tmo_val_i | input | CNT_W | Timeout length in prescaler ticks |
| bytes_left_i | input | 1 | Remaining transfer size is nonzero |
| sink_ready_i | input | 1 | Stream sink can accept data |
| tmo_pulse_o | output | 1 | One-cycle pulse to set the stream-timeout flag |

## Verification
The bench sweeps small prescaler and count values, including a count of zero, and checks the exact cycle of every pulse. An off-by-one in the prescaler wrap or in the tick count would move the pulse by one cycle or by one tick period. A cancel that arrives on the expiry edge itself is tested, because a design that gives expiry priority would leak a pulse there. Three further cases are covered: a stall that is cancelled and re-armed, a configuration change during a run, and an enable that is dropped during a run. These expose a counter that is not restarted, fields that are read live instead of latched, and a pulse that ignores the enable. A long stall after expiry catches a timer that reloads itself.

// File: rtl/stream_bp_timer_pkg.sv
package stream_bp_timer_pkg;
  typedef enum logic [1:0] {
    TMO_IDLE  = 2'd0,
    TMO_RUN   = 2'd1,
    TMO_SPENT = 2'd2
  } tmo_state_e;
endpackage

// File: rtl/bp_prescaler.sv
module bp_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pc_q, pc_d;
  logic [PRE_W-1:0] lim_q, lim_d;

  assign tick_o = run_i && (pc_q == lim_q);

  always_comb begin
    pc_d  = pc_q;
    lim_d = lim_q;
    if (load_i) begin
      pc_d  = '0;
      lim_d = limit_i;
    end else if (run_i) begin
      pc_d = (pc_q == lim_q) ? '0 : pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      lim_q <= '0;
    end else begin
      pc_q  <= pc_d;
      lim_q <= lim_d;
    end
  end

  // R3: the phase counter never passes the latched limit while running
  p_presc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (pc_q <= lim_q));

  // R7: loading restarts the phase from zero
  p_presc_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (pc_q == '0));
endmodule

// File: rtl/bp_tmo_count.sv
module bp_tmo_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last_o = (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = (load_val_i == '0) ? ONE : load_val_i;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: a freshly loaded count is never zero
  p_cnt_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q != '0));
endmodule

// File: rtl/stream_bp_timer.sv
module stream_bp_timer
  import stream_bp_timer_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmo_en_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic [CNT_W-1:0] tmo_val_i,
  input  logic             bytes_left_i,
  input  logic             sink_ready_i,
  output logic             tmo_pulse_o
);
  tmo_state_e state_q, state_d;
  logic       pulse_q, pulse_d;
  logic       stall, arm, load, running, tick, last;

  assign stall   = bytes_left_i && !sink_ready_i;
  assign arm     = tmo_en_i && stall;
  assign running = (state_q == TMO_RUN);
  assign load    = (state_q == TMO_IDLE) && arm;

  bp_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .run_i   (running),
    .limit_i (presc_i),
    .tick_o  (tick)
  );

  bp_tmo_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (tmo_val_i),
    .tick_i     (tick),
    .last_o     (last)
  );

  always_comb begin
    state_d = state_q;
    pulse_d = 1'b0;
    unique case (state_q)
      TMO_IDLE: if (arm) state_d = TMO_RUN;
      TMO_RUN: begin
        if (!stall) begin
          state_d = TMO_IDLE;
        end else if (tick && last) begin
          state_d = TMO_SPENT;
          pulse_d = tmo_en_i;
        end
      end
      TMO_SPENT: if (!stall) state_d = TMO_IDLE;
      default: state_d = TMO_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TMO_IDLE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign tmo_pulse_o = pulse_q;

  // R5: pulse is a single cycle
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse_o |=> !tmo_pulse_o);

  // R9: a pulse requires the enable on the expiry edge
  p_pulse_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse_o |-> $past(tmo_en_i));

  // R6: a pulse requires a stall on the expiry edge
  p_pulse_needs_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse_o |-> $past(stall));

  // R6: service resuming abandons the run
  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !stall) |=> (state_q == TMO_IDLE));

  // R2: no arm without enable, pending bytes and a stalled sink
  p_no_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TMO_IDLE) && !arm) |=> (state_q == TMO_IDLE));
endmodule

// File: tb/test_stream_bp_timer.sv
module test_stream_bp_timer;
  localparam int PRE_W = 12;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tmo_en_i;
  logic [PRE_W-1:0] presc_i;
  logic [CNT_W-1:0] tmo_val_i;
  logic             bytes_left_i;
  logic             sink_ready_i;
  logic             tmo_pulse_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  stream_bp_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) i_stream_bp_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .tmo_en_i     (tmo_en_i),
    .presc_i      (presc_i),
    .tmo_val_i    (tmo_val_i),
    .bytes_left_i (bytes_left_i),
    .sink_ready_i (sink_ready_i),
    .tmo_pulse_o  (tmo_pulse_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pulse actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // n_fire = expiry distance in edges from arm edge; 0 means no pulse expected
  task automatic watch(input int n_fire, input int window, input string req);
    for (int k = 1; k <= window; k++) begin
      @(negedge clk);
      chk(tmo_pulse_o, (n_fire > 0) && (k == n_fire + 1), req);
    end
  endtask

  task automatic release_stall();
    sink_ready_i = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    rst_n        = 1'b0;
    tmo_en_i     = 1'b1;
    presc_i      = '0;
    tmo_val_i    = 12'd1;
    bytes_left_i = 1'b1;
    sink_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(tmo_pulse_o, 1'b0, "R1 in reset");
    sink_ready_i = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(tmo_pulse_o, 1'b0, "R1 after reset");
    @(negedge clk);

    // R3/R4 sweep over small prescaler and count values
    for (int p = 0; p < 4; p++) begin
      for (int t = 0; t < 5; t++) begin
        int n;
        n = ((t == 0) ? 1 : t) * (p + 1);
        presc_i   = PRE_W'(p);
        tmo_val_i = CNT_W'(t);
        sink_ready_i = 1'b0;
        watch(n, n + 4, (t == 0) ? "R4 zero count" : "R3 expiry timing");
        release_stall();
      end
    end

    // R5: long stall after expiry gives only one pulse
    presc_i = 12'd1; tmo_val_i = 12'd2;
    sink_ready_i = 1'b0;
    watch(4, 20, "R5 one-shot");
    release_stall();

    // R2: disabled stall never pulses, enable rising mid-stall arms then
    tmo_en_i = 1'b0; presc_i = 12'd0; tmo_val_i = 12'd3;
    sink_ready_i = 1'b0;
    watch(0, 15, "R2 disabled");
    tmo_en_i = 1'b1;
    watch(3, 8, "R2 enable arms");
    release_stall();

    // R10: no pending bytes, no arm
    bytes_left_i = 1'b0;
    sink_ready_i = 1'b0;
    watch(0, 12, "R10 nothing pending");
    bytes_left_i = 1'b1;
    release_stall();

    // R6: cancel seen on the expiry edge itself
    presc_i = 12'd1; tmo_val_i = 12'd3;
    sink_ready_i = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk(tmo_pulse_o, 1'b0, "R6 before cancel");
    end
    sink_ready_i = 1'b1;
    watch(0, 6, "R6 cancel at expiry edge");

    // R6: cancel by pending bytes dropping
    sink_ready_i = 1'b0;
    watch(0, 2, "R6 early run");
    bytes_left_i = 1'b0;
    watch(0, 10, "R6 cancel by size");
    bytes_left_i = 1'b1;
    release_stall();

    // R7: cancel then re-arm restarts from zero
    presc_i = 12'd1; tmo_val_i = 12'd2;
    sink_ready_i = 1'b0;
    watch(0, 3, "R7 first run");
    sink_ready_i = 1'b1;
    watch(0, 1, "R7 cancelled");
    sink_ready_i = 1'b0;
    watch(4, 8, "R7 fresh count");
    release_stall();

    // R8: fields changed during the run are ignored
    presc_i = 12'd1; tmo_val_i = 12'd2;
    sink_ready_i = 1'b0;
    watch(0, 1, "R8 armed");
    presc_i = 12'd3; tmo_val_i = 12'd7;
    watch(3, 6, "R8 latched config");
    release_stall();

    // R9: enable dropped during run suppresses the pulse
    presc_i = 12'd0; tmo_val_i = 12'd3;
    sink_ready_i = 1'b0;
    watch(0, 1, "R9 armed");
    tmo_en_i = 1'b0;
    watch(0, 10, "R9 enable dropped");
    release_stall();
    tmo_en_i = 1'b1;

    report();
  end
endmodule